// File: doc/BRIEF.md
# Multi-Mode Serial Result Port

This block is the output side of a measurement converter. The converter core gives it a 16-bit result with a one-cycle strobe. The port holds that result and shifts it out serially in one of three formats. In the first format the port makes its own serial clock. In the second, a clock driven from outside moves the bits. In the third, the result leaves as two UART-style characters whose bit time is set by the external clock. An active-low ready flag tells the host when a fresh result is waiting. An active-low select starts and stops a read. The serial clock and data pins are three-state; here each is shown as a value plus an output-enable.

The controller has four states. ST_IDLE means no unread result is held. ST_HOLD lasts a fixed number of cycles while a new result is being taken in, and the ready flag is forced high during it. ST_READY means the result is held and the flag is low. ST_SHIFT means the result is being shifted out. The transitions are:
- IDLE to HOLD on an accepted strobe.
- HOLD to READY when the hold count expires.
- READY to HOLD on a fresh strobe, which replaces the unread result.
- READY to SHIFT when the synchronised select is low.
- SHIFT to IDLE when the last bit is done (normal end).
- SHIFT to IDLE when the select goes high (abort).

The select and external clock pins pass through two-flop synchronisers.

Top module: `ser_out_port`

## Requirements
- R1: After reset, `rdy_n` is 1 and both `sdata_oe` and `sclk_oe` are 0.
- R2: A `word_stb` accepted while no read is in progress keeps `rdy_n` at 1 for exactly RDY_HOLD (4) cycles after the strobe edge. `rdy_n` then falls, and the port holds `word_in` as sampled at that strobe.
- R3: A read starts only while `rdy_n` is 0 and the synchronised `cs_n` is 0. `rdy_n` returns to 1 in the cycle the transmission begins.
- R4: The synchronous formats are `mode_sel` 2'b00 (self-clocked) and 2'b01 (external clock). In both, the 16 data bits leave on `sdata` MSB first, with no extra bits.
- R5: In self-clocked mode, `sclk_oe` is 1 only while shifting. `sclk_out` has a period of SCK_DIV (4) clocks: low for the first half, high for the second. A new bit appears while `sclk_out` is low, and there are exactly 16 rising edges.
- R6: In external-clock mode, each falling edge of `sclk_in` moves the next bit onto `sdata`, and `sclk_oe` stays 0.
- R7: `mode_sel` 2'b10 or 2'b11 selects the character format. The frame is two 11-bit characters, high byte first. Each character is a 0 start bit, then 8 data bits MSB first, then two 1 stop bits. Each falling edge of `sclk_in` moves to the next bit.
- R8: Once the last bit of a frame is done, `sdata_oe` and `sclk_oe` go to 0 even if `cs_n` is held low. No new read starts until a new result is ready.
- R9: If `cs_n` goes high during a read, both enables are 0 within three clock edges. The rest of the result is dropped and `rdy_n` stays 1.
- R10: A `word_stb` that arrives while a read is in progress or during the hold window has no effect.
- R11: With `cs_n` held low all the time, every result offered is sent out in full, one after another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Format: 00 self-clocked, 01 external clock, 1x character format |
| word_in | input | 16 | Result from the converter core |
| word_stb | input | 1 | One-cycle strobe offering `word_in` |
| cs_n | input | 1 | Active-low read select (asynchronous) |
| sclk_in | input | 1 | External shift or bit-rate clock (asynchronous) |
| sclk_out | output | 1 | Generated serial clock, self-clocked mode |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Drive enable for the data pin |
| rdy_n | output | 1 | Active-low result-ready flag |

## Verification
The bench attacks the timing of the ready flag. A hold that is one cycle short or long moves the falling edge of `rdy_n` off the fifth cycle. A strobe that is not ignored during the hold or the shift makes the wrong word come out, or starts a second read when none is wanted. It also checks that a read ends on its own with the select still low. A design that waited for the select to rise would leave the pins driven, and one that counted frame lengths wrong would send 16 bits in character mode or cut off the stop bits. Aborts in the middle of a word have to float the pins at once and drop the result, rather than send it again.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_READY = 2'd2,
        ST_SHIFT = 2'd3
    } port_state_e;

    localparam logic [1:0] MD_SELF = 2'b00;
    localparam logic [1:0] MD_EXT  = 2'b01;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ser_clkgen.sv
module ser_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic bit_end
);

    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PH_W-1:0] ph_q;

    assign bit_end = run && (ph_q == PH_W'(DIV - 1));
    assign sclk    = run && (ph_q >= PH_W'(DIV / 2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ph_q <= '0;
        else if (!run || bit_end) ph_q <= '0;
        else                      ph_q <= ph_q + 1'b1;
    end

endmodule

// File: rtl/ser_framer.sv
module ser_framer #(
    parameter int WORD_W    = 16,
    parameter int CHAR_W    = 8,
    parameter int STOP_BITS = 2,
    parameter int FRAME_W   = 22,
    parameter int CNT_W     = 5
) (
    input  logic [WORD_W-1:0]  word,
    input  logic               async_en,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   frame_len
);

    localparam int CHARS    = WORD_W / CHAR_W;
    localparam int CHAR_LEN = 1 + CHAR_W + STOP_BITS;
    localparam int PAD_W    = FRAME_W - WORD_W;

    wire [FRAME_W-1:0] async_frame;

    for (genvar c = 0; c < CHARS; c++) begin : g_char
        localparam int HI = FRAME_W - 1 - c * CHAR_LEN;
        assign async_frame[HI]                      = 1'b0;
        assign async_frame[HI-1 -: CHAR_W]          = word[WORD_W-1-c*CHAR_W -: CHAR_W];
        assign async_frame[HI-1-CHAR_W -: STOP_BITS] = {STOP_BITS{1'b1}};
    end

    assign frame     = async_en ? async_frame : {word, {PAD_W{1'b0}}};
    assign frame_len = async_en ? CNT_W'(FRAME_W) : CNT_W'(WORD_W);

endmodule

// File: rtl/ser_out_port.sv
module ser_out_port
    import ser_port_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int CHAR_W    = 8,
    parameter int STOP_BITS = 2,
    parameter int SCK_DIV   = 4,
    parameter int RDY_HOLD  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_stb,
    input  logic              cs_n,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              rdy_n
);

    localparam int CHARS    = WORD_W / CHAR_W;
    localparam int CHAR_LEN = 1 + CHAR_W + STOP_BITS;
    localparam int FRAME_W  = CHARS * CHAR_LEN;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int HOLD_W   = $clog2(RDY_HOLD + 1);

    port_state_e          state_q, state_d;
    logic [WORD_W-1:0]    word_q;
    logic [HOLD_W-1:0]    hold_cnt;
    logic [FRAME_W-1:0]   sh_q;
    logic [CNT_W-1:0]     bit_cnt;
    logic [CNT_W-1:0]     len_q;
    logic [1:0]           mode_q;
    logic                 cs_s, sclk_s, sclk_d;
    logic                 run_self, gen_sclk, gen_end;
    logic [FRAME_W-1:0]   frame;
    logic [CNT_W-1:0]     frame_len;
    logic                 fall, adv, last, accept, start;

    ser_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk_in}),
        .q     ({cs_s, sclk_s})
    );

    ser_clkgen #(.DIV(SCK_DIV)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_self),
        .sclk    (gen_sclk),
        .bit_end (gen_end)
    );

    ser_framer #(
        .WORD_W    (WORD_W),
        .CHAR_W    (CHAR_W),
        .STOP_BITS (STOP_BITS),
        .FRAME_W   (FRAME_W),
        .CNT_W     (CNT_W)
    ) u_framer (
        .word      (word_q),
        .async_en  (mode_sel[1]),
        .frame     (frame),
        .frame_len (frame_len)
    );

    assign run_self = (state_q == ST_SHIFT) && (mode_q == MD_SELF);
    assign fall     = sclk_d && !sclk_s;
    assign adv      = (mode_q == MD_SELF) ? gen_end : fall;
    assign last     = (bit_cnt + CNT_W'(1)) == len_q;
    assign accept   = word_stb && ((state_q == ST_IDLE) || (state_q == ST_READY));
    assign start    = (state_q == ST_READY) && !word_stb && !cs_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (word_stb) state_d = ST_HOLD;
            ST_HOLD:  if (hold_cnt == HOLD_W'(RDY_HOLD - 1)) state_d = ST_READY;
            ST_READY: begin
                if (word_stb)  state_d = ST_HOLD;
                else if (!cs_s) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_s)              state_d = ST_IDLE;
                else if (adv && last)  state_d = ST_IDLE;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            hold_cnt <= '0;
            sh_q     <= '0;
            bit_cnt  <= '0;
            len_q    <= '0;
            mode_q   <= MD_SELF;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d   <= sclk_s;
            hold_cnt <= (state_q == ST_HOLD) ? hold_cnt + 1'b1 : '0;
            if (accept) word_q <= word_in;
            if (start) begin
                sh_q    <= frame;
                len_q   <= frame_len;
                mode_q  <= mode_sel;
                bit_cnt <= '0;
            end else if ((state_q == ST_SHIFT) && adv) begin
                sh_q    <= {sh_q[FRAME_W-2:0], 1'b1};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rdy_n    = (state_q != ST_READY);
        sdata_oe = (state_q == ST_SHIFT);
        sclk_oe  = run_self;
        sclk_out = gen_sclk;
        sdata    = sh_q[FRAME_W-1];
    end

endmodule

// File: rtl/ser_out_port_chk.sv
module ser_out_port_chk #(
    parameter int RDY_HOLD = 4
) (
    input logic clk,
    input logic rst_n,
    input logic word_stb,
    input logic cs_n,
    input logic sclk_oe,
    input logic sdata_oe,
    input logic rdy_n
);

    localparam int HC_W = $clog2(RDY_HOLD + 2);

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           hi_cnt <= '0;
        else if (!rdy_n)                      hi_cnt <= '0;
        else if (hi_cnt != HC_W'(RDY_HOLD))   hi_cnt <= hi_cnt + 1'b1;
    end

    a_r2_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> (hi_cnt >= HC_W'(RDY_HOLD)));

    a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> rdy_n);

    a_r3_start_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $past(!rdy_n));

    a_r5_sclk_only_shifting: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe |-> sdata_oe);

    a_r9_release_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!sdata_oe && !sclk_oe));

    a_r10_busy_stb_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && word_stb) |=> rdy_n);

endmodule

bind ser_out_port ser_out_port_chk #(.RDY_HOLD(RDY_HOLD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_stb (word_stb),
    .cs_n     (cs_n),
    .sclk_oe  (sclk_oe),
    .sdata_oe (sdata_oe),
    .rdy_n    (rdy_n)
);

// File: tb/ser_out_port_tb.sv
`timescale 1ns/1ps
module ser_out_port_tb;

    localparam int SCK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [15:0] word_in = '0;
    logic        word_stb = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sclk_out, sclk_oe, sdata, sdata_oe, rdy_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    ser_out_port u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .word_in(word_in),
        .word_stb(word_stb), .cs_n(cs_n), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata(sdata),
        .sdata_oe(sdata_oe), .rdy_n(rdy_n)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [21:0] exp_frame(input logic [1:0] m, input logic [15:0] w);
        if (m[1]) return {1'b0, w[15:8], 2'b11, 1'b0, w[7:0], 2'b11};
        return {w, 6'b0};
    endfunction

    function automatic int exp_len(input logic [1:0] m);
        return m[1] ? 22 : 16;
    endfunction

    task automatic send_word(input logic [15:0] w);
        @(negedge clk); word_in = w; word_stb = 1'b1;
        @(negedge clk); word_stb = 1'b0;
    endtask

    task automatic wait_ready();
        for (int g = 0; g < 50 && rdy_n; g++) @(negedge clk);
    endtask

    task automatic rx_self(output logic [21:0] got, output int n, output int badp,
                           output logic rdy_at_start);
        int gap; logic prev;
        got = '0; n = 0; badp = 0; gap = 0; prev = 1'b0;
        for (int g = 0; g < 200 && !sdata_oe; g++) @(negedge clk);
        rdy_at_start = rdy_n;
        while (sdata_oe) begin
            if (!sclk_oe) badp++;
            if (sclk_out && !prev) begin
                if (n > 0 && gap != SCK_DIV) badp++;
                if (n < 22) got[21-n] = sdata;
                n++; gap = 0;
            end
            prev = sclk_out; gap++;
            @(negedge clk);
        end
    endtask

    task automatic rx_edge(input int len, output logic [21:0] got, output int n,
                           output int badp, output logic rdy_at_start);
        got = '0; n = 0; badp = 0;
        for (int g = 0; g < 200 && !sdata_oe; g++) @(negedge clk);
        rdy_at_start = rdy_n;
        for (int i = 0; i < len; i++) begin
            repeat (4) @(negedge clk);
            sclk_in = 1'b1;
            @(negedge clk);
            if (!sdata_oe) break;
            got[21-i] = sdata; n++;
            if (sclk_oe) badp++;
            repeat (3) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic read_word(input logic [1:0] m, output logic [21:0] got, output int n,
                             output int badp, output logic rdy_at_start);
        if (m == 2'b00) rx_self(got, n, badp, rdy_at_start);
        else            rx_edge(exp_len(m), got, n, badp, rdy_at_start);
    endtask

    initial begin
        logic [21:0] got; int n; int badp; logic ras;
        logic [15:0] w; logic [1:0] m;
        void'($urandom(32'h5EED_0042));

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(rdy_n == 1'b1, "R1", "rdy_n in reset", rdy_n, 1);
        chk(sdata_oe == 1'b0, "R1", "sdata_oe in reset", sdata_oe, 0);
        chk(sclk_oe == 1'b0, "R1", "sclk_oe in reset", sclk_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 hold window timing
        mode_sel = 2'b00;
        @(negedge clk); word_in = 16'hA5C3; word_stb = 1'b1;
        @(negedge clk); word_stb = 1'b0;
        chk(rdy_n == 1'b1, "R2", "rdy_n hold cycle 1", rdy_n, 1);
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk);
            chk(rdy_n == 1'b1, "R2", "rdy_n during hold", rdy_n, 1);
        end
        @(negedge clk);
        chk(rdy_n == 1'b0, "R2", "rdy_n after hold", rdy_n, 0);

        // R3, R4, R5 self-clocked read; R8 end with cs low
        cs_n = 1'b0;
        rx_self(got, n, badp, ras);
        chk(ras == 1'b1, "R3", "rdy_n once shifting", ras, 1);
        chk(n == 16, "R4", "self bit count", n, 16);
        chk(got == exp_frame(2'b00, 16'hA5C3), "R4", "self word", got, exp_frame(2'b00, 16'hA5C3));
        chk(badp == 0, "R5", "sclk period errors", badp, 0);
        repeat (20) @(negedge clk);
        chk(sdata_oe == 1'b0 && sclk_oe == 1'b0, "R8", "pins float after word", {sdata_oe, sclk_oe}, 0);
        chk(rdy_n == 1'b1, "R8", "no re-read", rdy_n, 1);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 strobe during hold window ignored
        send_word(16'h1234);
        send_word(16'hFEDC);
        wait_ready();
        mode_sel = 2'b01;
        cs_n = 1'b0;
        rx_edge(16, got, n, badp, ras);
        chk(got == exp_frame(2'b01, 16'h1234), "R10", "hold strobe word", got, exp_frame(2'b01, 16'h1234));
        chk(badp == 0, "R6", "sclk_oe in ext mode", badp, 0);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9 abort mid-word
        send_word(16'h0F0F);
        wait_ready();
        cs_n = 1'b0;
        for (int g = 0; g < 50 && !sdata_oe; g++) @(negedge clk);
        repeat (10) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sdata_oe == 1'b0, "R9", "float after release", sdata_oe, 0);
        cs_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(sdata_oe == 1'b0, "R9", "dropped word not resent", sdata_oe, 0);
        chk(rdy_n == 1'b1, "R9", "rdy_n after abort", rdy_n, 1);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 strobe during shifting ignored
        mode_sel = 2'b00;
        send_word(16'h5555);
        wait_ready();
        cs_n = 1'b0;
        for (int g = 0; g < 50 && !sdata_oe; g++) @(negedge clk);
        repeat (10) @(negedge clk);
        send_word(16'hAAAA);
        for (int g = 0; g < 200 && sdata_oe; g++) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(sdata_oe == 1'b0 && rdy_n == 1'b1, "R10", "busy strobe ignored", {sdata_oe, rdy_n}, 1);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11 select held low, consecutive words
        cs_n = 1'b0;
        send_word(16'hBEEF);
        rx_self(got, n, badp, ras);
        chk(got == exp_frame(2'b00, 16'hBEEF), "R11", "first streamed word", got, exp_frame(2'b00, 16'hBEEF));
        send_word(16'h0001);
        rx_self(got, n, badp, ras);
        chk(got == exp_frame(2'b00, 16'h0001), "R11", "second streamed word", got, exp_frame(2'b00, 16'h0001));
        cs_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7 directed character frame with extreme bytes
        mode_sel = 2'b10;
        send_word(16'hFF00);
        wait_ready();
        cs_n = 1'b0;
        rx_edge(22, got, n, badp, ras);
        chk(n == 22, "R7", "char frame length", n, 22);
        chk(got == exp_frame(2'b10, 16'hFF00), "R7", "char frame", got, exp_frame(2'b10, 16'hFF00));
        cs_n = 1'b1;
        repeat (5) @(negedge clk);

        // random mix over all modes (R4, R6, R7)
        for (int it = 0; it < 16; it++) begin
            m = 2'($urandom_range(0, 3));
            w = 16'($urandom);
            mode_sel = m;
            send_word(w);
            wait_ready();
            cs_n = 1'b0;
            read_word(m, got, n, badp, ras);
            if (m[1]) chk(got == exp_frame(m, w) && n == 22, "R7", "random char frame", got, exp_frame(m, w));
            else if (m[0]) chk(got == exp_frame(m, w) && n == 16, "R6", "random ext word", got, exp_frame(m, w));
            else chk(got == exp_frame(m, w) && n == 16 && badp == 0, "R5", "random self word", got, exp_frame(m, w));
            cs_n = 1'b1;
            repeat (6) @(negedge clk);
        end

        summary();
        $finish;
    end

endmodule